// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Group

This block models eight spiking neurons that share a configuration. Each neuron owns an 8-bit integration counter that advances on every oscillation pulse arriving on its strobe input. When a pulse would bring the counter up to the programmed threshold, the neuron emits a one-cycle spike and its counter restarts from zero. Every spike also increments a 16-bit saturating total, which is brought out for readout.

Two optional mechanisms lower activity. Leak runs off a free-running timer with a programmable period. On each timer tick it clears bit 0 of every counter. Lateral inhibition lets any spiking neuron clear a programmable set of counter bits in every other neuron that is not spiking in the same cycle. A faster neuron therefore holds its slower neighbours back more than they hold it back. With both mechanisms off, the group is a plain integrate-and-fire array. A synchronous clear input restarts counters, totals and the leak timer.

Top module: `lif_group`

## Requirements
- R1: After reset is released, every spike output is 0 and every spike total reads 0.
- R2: A neuron's counter rises by exactly one per cycle in which its pulse strobe is high, and holds while the strobe is low.
- R3: A neuron fires on a pulse that brings its count (old count plus one) to at least the threshold. Its spike output is high for exactly the cycle after that pulse, and its counter restarts from 0. With threshold 16 and no leak, the spike follows the 16th pulse. A spike needs a pulse in the cycle before it.
- R4: The leak timer ticks once every P cycles, where P is the leak period input (0 is treated as 1), counting from reset or clear. When leak is enabled, each tick clears bit 0 of every counter, and any pulse in that cycle is discarded.
- R5: With leak and inhibition both disabled, each neuron with a steady pulse stream fires once every threshold pulses, whatever the leak period and the inhibition mask are.
- R6: When inhibition is enabled, a spiking neuron clears the mask bits (bit k of the mask clears counter bit k) in the counter of every neuron not spiking in that cycle. The mask is applied after that cycle's increment.
- R7: Neurons that fire in the same cycle each restart from 0 and are never inhibited in that cycle.
- R8: When inhibition is disabled, spikes have no effect on other counters, whatever the mask holds.
- R9: Each spike total counts spikes and saturates at 65535. It never decreases except on clear.
- R10: A high clear input zeroes all counters, totals, spike outputs and the leak timer at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all state |
| pulse_i | input | 8 | One oscillation pulse strobe per neuron |
| thresh_i | input | 8 | Spiking threshold |
| leak_period_i | input | 16 | Leak timer period in cycles |
| leak_en_i | input | 1 | Enables the periodic clearing of bit 0 |
| inhib_en_i | input | 1 | Enables lateral inhibition |
| inhib_mask_i | input | 8 | Counter bits that a peer's spike clears |
| spike_o | output | 8 | One-cycle spike per neuron |
| total_o | output | 128 | Per-neuron 16-bit spike totals, neuron n in bits 16n+15:16n |

## Verification
The counters are not visible at the ports, so a wrong counter value shows up only as a shifted or missing spike. The spike arrives one or more pulses early or late, within one threshold period of the fault. Leak and inhibition faults are found by running fixed pulse patterns against hand-derived spike totals. Different thresholds, leak periods and mask bits make a wrong bit, a wrong priority or a wrong neuron choice change the total. The bench checks the spike timing at its exact edge, confirms that clear restarts the whole threshold, and drives a neuron into saturation of its total.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int unsigned NEUR_N = 8;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned TOT_W  = 16;
  localparam int unsigned LEAK_W = 16;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_LEAK = 2'd2
  } upd_e;
endpackage

// File: rtl/lif_leak_timer.sv
module lif_leak_timer #(
  parameter int unsigned LEAK_W = lif_pkg::LEAK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [LEAK_W-1:0] period_i,
  output logic              tick_o
);
  logic [LEAK_W-1:0] t_q;
  logic              last;

  always_comb begin
    if (period_i <= LEAK_W'(1)) last = 1'b1;
    else                        last = (t_q >= period_i - LEAK_W'(1));
  end

  assign tick_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      t_q <= '0;
    else if (clr_i)   t_q <= '0;
    else if (last)    t_q <= '0;
    else              t_q <= t_q + LEAK_W'(1);
  end

  AST_LEAK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && period_i > LEAK_W'(1)) |=> (!tick_o || !$stable(period_i))) else $error("leak tick twice in a row"); // R4
endmodule

// File: rtl/lif_inhibit.sv
module lif_inhibit #(
  parameter int unsigned NEUR_N = lif_pkg::NEUR_N
) (
  input  logic [NEUR_N-1:0] fire_i,
  input  logic              en_i,
  output logic [NEUR_N-1:0] hit_o
);
  for (genvar g = 0; g < NEUR_N; g++) begin : g_hit
    logic [NEUR_N-1:0] peers;
    always_comb begin
      peers    = fire_i;
      peers[g] = 1'b0;
    end
    // a spiking neuron restarts itself and is never inhibited
    assign hit_o[g] = en_i && (|peers) && !fire_i[g];
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int unsigned CNT_W = lif_pkg::CNT_W,
  parameter int unsigned TOT_W = lif_pkg::TOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             leak_i,
  input  logic             inhib_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             fire_o,
  output logic             spike_o,
  output logic [TOT_W-1:0] total_o
);
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_upd;
  logic [CNT_W:0]   inc_w;
  logic             spike_q;
  logic [TOT_W-1:0] tot_q;
  upd_e             upd;

  always_comb begin
    if (leak_i)       upd = UPD_LEAK;
    else if (pulse_i) upd = UPD_INC;
    else              upd = UPD_HOLD;
  end

  assign inc_w  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign fire_o = (upd == UPD_INC) && (inc_w >= {1'b0, thresh_i});

  always_comb begin
    unique case (upd)
      UPD_INC:  cnt_upd = inc_w[CNT_W-1:0];
      UPD_LEAK: cnt_upd = cnt_q & ~CNT_W'(1);
      default:  cnt_upd = cnt_q;
    endcase
    if (fire_o)       cnt_d = '0;
    else if (inhib_i) cnt_d = cnt_upd & ~mask_i;
    else              cnt_d = cnt_upd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      spike_q <= 1'b0;
      tot_q   <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      spike_q <= 1'b0;
      tot_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      spike_q <= fire_o;
      if (fire_o && tot_q != TOT_MAX) tot_q <= tot_q + TOT_W'(1);
    end
  end

  assign spike_o = spike_q;
  assign total_o = tot_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("counter jumped"); // R2
  AST_SPIKE_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_q |-> $past(pulse_i)) else $error("spike without pulse"); // R3
  AST_LEAK_BLOCKS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(leak_i) |-> !spike_q) else $error("spike on leak tick"); // R4
  AST_TOTAL_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (tot_q >= $past(tot_q))) else $error("total decreased"); // R9
  AST_TOTAL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_q && !$past(clr_i) && $past(tot_q) != TOT_MAX) |-> (tot_q == $past(tot_q) + TOT_W'(1))) else $error("total missed spike"); // R9
endmodule

// File: rtl/lif_group.sv
module lif_group
  import lif_pkg::*;
#(
  parameter int unsigned N_NEUR = lif_pkg::NEUR_N,
  parameter int unsigned CW     = lif_pkg::CNT_W,
  parameter int unsigned TW     = lif_pkg::TOT_W,
  parameter int unsigned LW     = lif_pkg::LEAK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [N_NEUR-1:0]  pulse_i,
  input  logic [CW-1:0]      thresh_i,
  input  logic [LW-1:0]      leak_period_i,
  input  logic               leak_en_i,
  input  logic               inhib_en_i,
  input  logic [CW-1:0]      inhib_mask_i,
  output logic [N_NEUR-1:0]  spike_o,
  output logic [N_NEUR*TW-1:0] total_o
);
  logic              tick;
  logic              leak_now;
  logic [N_NEUR-1:0] fire;
  logic [N_NEUR-1:0] hit;

  lif_leak_timer #(.LEAK_W(LW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .period_i (leak_period_i),
    .tick_o   (tick)
  );

  assign leak_now = leak_en_i && tick;

  lif_inhibit #(.NEUR_N(N_NEUR)) u_inhib (
    .fire_i (fire),
    .en_i   (inhib_en_i),
    .hit_o  (hit)
  );

  for (genvar g = 0; g < N_NEUR; g++) begin : g_neur
    lif_neuron #(.CNT_W(CW), .TOT_W(TW)) u_neuron (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .pulse_i  (pulse_i[g]),
      .thresh_i (thresh_i),
      .leak_i   (leak_now),
      .inhib_i  (hit[g]),
      .mask_i   (inhib_mask_i),
      .fire_o   (fire[g]),
      .spike_o  (spike_o[g]),
      .total_o  (total_o[g*TW +: TW])
    );
  end

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (spike_o == '0)) else $error("spike after clear"); // R10
  AST_ONLY_PULSED_SPIKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((spike_o & ~$past(pulse_i)) == '0)) else $error("spike on unpulsed neuron"); // R3
  AST_HIT_NEEDS_PEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |-> ($countones(fire) >= 1 && inhib_en_i)) else $error("inhibition without spike"); // R6
endmodule

// File: tb/lif_group_tb.sv
module lif_group_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [7:0]  thr;
    logic [15:0] per;
    logic        leak;
    logic        inh;
    logic [7:0]  mask;
    logic [7:0]  pa;
    logic [7:0]  pb;
    logic [15:0] edges;
    logic [15:0] e0;
    logic [15:0] e1;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    '{8'd16, 16'd1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFF, 16'd48, 16'd3,  16'd3},  // R5 plain
    '{8'd2,  16'd2, 1'b1, 1'b0, 8'h00, 8'h03, 8'h03, 16'd20, 16'd0,  16'd0},  // R4 leak holds below thr
    '{8'd2,  16'd2, 1'b0, 1'b0, 8'h00, 8'h03, 8'h03, 16'd20, 16'd10, 16'd10}, // R5 same without leak
    '{8'd3,  16'd3, 1'b1, 1'b0, 8'h00, 8'h01, 8'h01, 16'd24, 16'd4,  16'd0},  // R4 period 3
    '{8'd4,  16'd1, 1'b0, 1'b1, 8'hFF, 8'h03, 8'h03, 16'd24, 16'd6,  16'd6},  // R7 simultaneous
    '{8'd4,  16'd1, 1'b0, 1'b1, 8'hFF, 8'h03, 8'h02, 16'd24, 16'd0,  16'd6},  // R6 fast suppresses slow
    '{8'd4,  16'd1, 1'b0, 1'b1, 8'h04, 8'h03, 8'h02, 16'd24, 16'd3,  16'd6},  // R6 mask bit 2 only
    '{8'd4,  16'd1, 1'b0, 1'b0, 8'hFF, 8'h03, 8'h02, 16'd24, 16'd3,  16'd6}   // R8 inhibition off
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [7:0]  pulse_i = '0;
  logic [7:0]  thresh_i = 8'd16;
  logic [15:0] leak_period_i = 16'd1;
  logic        leak_en_i = 1'b0;
  logic        inhib_en_i = 1'b0;
  logic [7:0]  inhib_mask_i = '0;
  logic [7:0]  spike_o;
  logic [127:0] total_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lif_group u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr_i),
    .pulse_i       (pulse_i),
    .thresh_i      (thresh_i),
    .leak_period_i (leak_period_i),
    .leak_en_i     (leak_en_i),
    .inhib_en_i    (inhib_en_i),
    .inhib_mask_i  (inhib_mask_i),
    .spike_o       (spike_o),
    .total_o       (total_o)
  );

  function automatic int tot(input int n);
    return int'(total_o[n*16 +: 16]);
  endfunction

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clr();
    clr_i = 1'b1;
    step();
    clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step();
    chk("R1 spikes after reset", int'(spike_o), 0);
    chk("R1 total n0 after reset", tot(0), 0);
    chk("R1 total n7 after reset", tot(7), 0);

    // table-driven scenarios
    for (int v = 0; v < NV; v++) begin
      thresh_i      = VECS[v].thr;
      leak_period_i = VECS[v].per;
      leak_en_i     = VECS[v].leak;
      inhib_en_i    = VECS[v].inh;
      inhib_mask_i  = VECS[v].mask;
      do_clr();
      for (int k = 0; k < int'(VECS[v].edges); k++) begin
        pulse_i = (k % 2 == 0) ? VECS[v].pa : VECS[v].pb;
        step();
      end
      pulse_i = '0;
      chk($sformatf("R4/R5/R6/R7/R8 vector %0d n0", v), tot(0), int'(VECS[v].e0));
      chk($sformatf("R4/R5/R6/R7/R8 vector %0d n1", v), tot(1), int'(VECS[v].e1));
    end

    // R3: threshold 16, exact spike edge
    thresh_i = 8'd16; leak_en_i = 1'b0; inhib_en_i = 1'b0; inhib_mask_i = '0;
    do_clr();
    pulse_i = 8'h08;
    step(15);
    chk("R3 no spike after 15 pulses", int'(spike_o), 0);
    step();
    chk("R3 spike after 16th pulse", int'(spike_o), 8'h08);
    chk("R3 total after first spike", tot(3), 1);
    pulse_i = '0;
    step();
    chk("R3 spike lasts one cycle", int'(spike_o), 0);

    // R2: gaps hold the count
    pulse_i = 8'h08; step(10);
    pulse_i = '0;    step(4);
    pulse_i = 8'h08; step(5);
    chk("R2 no spike after 15 gapped pulses", int'(spike_o), 0);
    step();
    pulse_i = '0;
    chk("R2 spike on 16th gapped pulse", int'(spike_o), 8'h08);
    chk("R2 total two", tot(3), 2);

    // R3: threshold lowered below current count
    do_clr();
    pulse_i = 8'h08; step(10);
    pulse_i = '0; thresh_i = 8'd5;
    step();
    chk("R3 no spike without pulse", int'(spike_o), 0);
    pulse_i = 8'h08; step();
    pulse_i = '0;
    chk("R3 fires when count exceeds lowered threshold", int'(spike_o), 8'h08);

    // R10: clear restarts the full threshold
    thresh_i = 8'd16;
    pulse_i = 8'h08; step(12);
    pulse_i = '0;
    do_clr();
    chk("R10 total cleared", tot(3), 0);
    chk("R10 spikes cleared", int'(spike_o), 0);
    pulse_i = 8'h08; step(15);
    chk("R10 counter restarted", int'(spike_o), 0);
    step();
    pulse_i = '0;
    chk("R10 spike after full 16", int'(spike_o), 8'h08);

    // R9: saturation
    thresh_i = 8'd1;
    do_clr();
    pulse_i = 8'h04;
    step(65540);
    chk("R9 total saturates", tot(2), 65535);
    chk("R9 spikes continue at saturation", int'(spike_o[2]), 1);
    chk("R9 other neuron untouched", tot(5), 0);
    pulse_i = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule